// File: doc/BRIEF.md
# Single-Channel Multi-Mode DMA Engine

This block moves a programmed number of data units between one peripheral and memory so that the CPU does not have to copy them itself. Software loads a start address, a unit count and a control word through a small register port. Setting the launch bit starts the engine. The engine first obtains the system bus through a request/grant pair. For each unit it then strobes the peripheral, runs one memory cycle, and waits for the peripheral to acknowledge before it steps the address and the count.

The control word selects the direction, the unit size (8 or 16 bits), the peripheral port number and one of three bus disciplines. In cycle-steal mode the bus is given back after every unit. In burst mode the bus is held for a programmed run of units. In fly-by mode the data does not pass through the engine's holding register. It crosses between the peripheral pins and the memory pins in the same cycle as the memory strobe. When the count reaches zero an interrupt line rises. It stays high until software acknowledges it.

Top module: `dma_mover`

## Requirements
- R1: After reset, the address and count registers read 0, `irq`, `bus_req`, `dev_req` and `mem_en` are low. A read selects a register with `cfg_sel` (0 address, 1 count, 2 control) and returns it on `cfg_rdata` one cycle later.
- R2: A launch with a nonzero count raises `bus_req`. No `dev_req` and no `mem_en` appear until `bus_gnt` is high.
- R3: Each unit asserts `dev_req`, then runs one memory cycle, then waits for `dev_ack`. On that acknowledge the address advances by 1 for byte units and by 2 for word units, and the count drops by 1.
- R4: Cycle-steal mode (control bits [5:4] = 00, and also 11) drops `bus_req` after every unit, so a transfer of N units raises `bus_req` N times.
- R5: Burst mode (bits [5:4] = 01) keeps `bus_req` high for bits [9:6] + 1 units, so N units raise `bus_req` ceil(N / (field+1)) times.
- R6: Fly-by mode (bits [5:4] = 10) asserts `dev_req` and `mem_en` in the same cycle. Peripheral data goes to memory, or memory data goes to the peripheral, without the holding register, and the bus is released after each unit.
- R7: Control bit 2 selects the direction: 0 writes peripheral data into memory, 1 reads memory and presents the data on `dev_wdata` while waiting for the acknowledge.
- R8: Control bit 3 selects word units (1) or byte units (0). Byte units carry only the low 8 bits, with the upper bits zero.
- R9: `irq` rises when the count reaches zero and stays high until a control write with bit 1 set. Reading the control register returns `irq` in bit 1.
- R10: Register writes, including a launch, are ignored while a transfer is in progress.
- R11: A launch with a count of zero raises `irq` on the next cycle and makes no bus request.
- R12: Control bits [13:10] select the peripheral port and appear on `dev_port`. The launch is control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Registered read data |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_en | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after strobe |
| dev_port | output | PORT_W | Selected peripheral port |
| dev_req | output | 1 | Peripheral service strobe |
| dev_ack | input | 1 | Peripheral acknowledge pulse |
| dev_rdata | input | DATA_W | Data from the peripheral |
| dev_wdata | output | DATA_W | Data to the peripheral |

## Verification
The assertions rely on the following input behaviour:
- `bus_gnt` is only high while `bus_req` is high, and once given it stays high until the engine drops the request.
- `dev_ack` is a one-cycle pulse that arrives no earlier than the acknowledge phase: 2 cycles after `dev_req` for writes, 3 for normal reads, 1 in fly-by.
- Memory returns read data one cycle after the strobe.

The bench meets these conditions as follows:
- The grant is derived from the request through a gate that is opened only while the engine waits.
- A peripheral model pulses the acknowledge after a per-test delay that is never shorter than these minimums.
- A memory model with one-cycle read latency supplies the read data.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int BLEN_W  = 4;
  localparam int PORT_W  = 4;
  localparam int F_START = 0;
  localparam int F_DONE  = 1;
  localparam int F_DIR   = 2;
  localparam int F_PORT  = 10;
  localparam int CTRL_HI = F_PORT + PORT_W - 1;

  typedef enum logic [1:0] {M_STEAL = 2'b00, M_BURST = 2'b01, M_FLY = 2'b10, M_RSVD = 2'b11} mode_e;
  typedef enum logic [1:0] {SEL_ADDR = 2'd0, SEL_CNT = 2'd1, SEL_CTRL = 2'd2, SEL_NONE = 2'd3} sel_e;

  // packed MSB first: lines up with control bits [13:2]
  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [BLEN_W-1:0] blen;
    mode_e             mode;
    logic              word;
    logic              dir;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_GRAB, S_DREQ, S_MEM, S_RD, S_FLY, S_ACK, S_GAP
  } st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              busy,
  input  logic              unit_done,
  input  logic              xfer_end,
  output logic              start_go,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] addr,
  output logic              cnt_last,
  output logic              irq
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] step;
  logic              wr_ok, ctrl_wr, zero_go;
  sel_e              sel;
  logic              unused_hi;

  assign sel       = sel_e'(cfg_sel);
  assign wr_ok     = cfg_we && !busy;
  assign ctrl_wr   = wr_ok && (sel == SEL_CTRL);
  assign start_go  = ctrl_wr && cfg_wdata[F_START] && (cnt_q != '0);
  assign zero_go   = ctrl_wr && cfg_wdata[F_START] && (cnt_q == '0);
  assign cnt_last  = (cnt_q == CNT_W'(1));
  assign step      = ctrl.word ? ADDR_W'(2) : ADDR_W'(1);
  assign unused_hi = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr      <= '0;
      cnt_q     <= '0;
      ctrl      <= '0;
      irq       <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      if (unit_done) begin
        addr  <= addr + step;
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        if (wr_ok && sel == SEL_ADDR) addr  <= cfg_wdata[ADDR_W-1:0];
        if (wr_ok && sel == SEL_CNT)  cnt_q <= cfg_wdata[CNT_W-1:0];
      end
      if (ctrl_wr) ctrl <= ctrl_t'(cfg_wdata[CTRL_HI:F_DIR]);
      if (xfer_end || zero_go)            irq <= 1'b1;
      else if (ctrl_wr && cfg_wdata[F_DONE]) irq <= 1'b0;
      case (sel)
        SEL_ADDR: cfg_rdata <= REG_W'(addr);
        SEL_CNT:  cfg_rdata <= REG_W'(cnt_q);
        SEL_CTRL: cfg_rdata <= REG_W'({ctrl, irq, 1'b0});
        default:  cfg_rdata <= '0;
      endcase
    end
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    unit_done |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    unit_done |=> addr == ADDR_W'($past(addr) + $past(step)));
  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_we && !unit_done) |=> $stable(addr) && $stable(cnt_q) && $stable(ctrl));
  // R9
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> cnt_q == '0);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(ctrl_wr && cfg_wdata[F_DONE])) |=> irq);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_go,
  input  mode_e             mode,
  input  logic [BLEN_W-1:0] blen,
  input  logic              dir,
  input  logic              cnt_last,
  input  logic              bus_gnt,
  input  logic              dev_ack,
  output logic              busy,
  output logic              unit_done,
  output logic              xfer_end,
  output logic              bus_req,
  output logic              dev_req,
  output logic              mem_en,
  output logic              mem_we,
  output logic              cap_dev,
  output logic              cap_mem,
  output logic              fly_wr,
  output logic              fly_rd
);
  st_e               st, nxt;
  logic [BLEN_W-1:0] beat;
  logic              fly, release_bus;

  assign fly         = (mode == M_FLY);
  assign release_bus = (mode != M_BURST) || (beat == blen);

  assign busy      = (st != S_IDLE);
  assign bus_req   = !(st inside {S_IDLE, S_GAP});
  assign dev_req   = (st == S_DREQ) || (st == S_FLY);
  assign mem_en    = (st == S_MEM) || (st == S_FLY);
  assign mem_we    = !dir;
  assign cap_dev   = (st == S_DREQ) && !dir;
  assign cap_mem   = (st == S_RD);
  assign fly_wr    = (st == S_FLY) && !dir;
  assign fly_rd    = (st == S_ACK) && fly && dir;
  assign unit_done = (st == S_ACK) && dev_ack;
  assign xfer_end  = unit_done && cnt_last;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (start_go) nxt = S_GRAB;
      S_GRAB: if (bus_gnt) nxt = fly ? S_FLY : S_DREQ;
      S_DREQ: nxt = S_MEM;
      S_MEM:  nxt = dir ? S_RD : S_ACK;
      S_RD:   nxt = S_ACK;
      S_FLY:  nxt = S_ACK;
      S_ACK:  if (dev_ack) nxt = cnt_last ? S_IDLE : (release_bus ? S_GAP : S_DREQ);
      default: nxt = S_GRAB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      beat <= '0;
    end else begin
      st <= nxt;
      if (st == S_GRAB)   beat <= '0;
      else if (unit_done) beat <= beat + BLEN_W'(1);
    end
  end

  // R2
  mem_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en || dev_req) |-> bus_gnt);
  // R4
  steal_release_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_done && mode != M_BURST) |=> !bus_req);
  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_done && mode == M_BURST && !cnt_last && beat != blen) |=> bus_req && dev_req);
  // R3
  ack_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACK && !dev_ack) |=> st == S_ACK && $stable(beat));
endmodule

// File: rtl/dma_data.sv
module dma_data #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word,
  input  logic              cap_dev,
  input  logic              cap_mem,
  input  logic              fly_wr,
  input  logic              fly_rd,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] dev_wdata
);
  localparam int BYTE_W = 8;
  logic [DATA_W-1:0] keep, hold, dev_m, mem_m;

  assign keep  = word ? '1 : DATA_W'({BYTE_W{1'b1}});
  assign dev_m = dev_rdata & keep;
  assign mem_m = mem_rdata & keep;

  always_ff @(posedge clk) begin
    if (rst)          hold <= '0;
    else if (cap_dev) hold <= dev_m;
    else if (cap_mem) hold <= mem_m;
  end

  assign mem_wdata = fly_wr ? dev_m : hold;
  assign dev_wdata = fly_rd ? mem_m : hold;

  // R8
  byte_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!word && (cap_dev || cap_mem)) |=> hold[DATA_W-1:BYTE_W] == '0);
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PORT_W-1:0] dev_port,
  output logic              dev_req,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata
);
  ctrl_t ctrl;
  logic  busy, unit_done, xfer_end, start_go, cnt_last;
  logic  cap_dev, cap_mem, fly_wr, fly_rd;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .busy(busy), .unit_done(unit_done), .xfer_end(xfer_end),
    .start_go(start_go), .ctrl(ctrl), .addr(mem_addr), .cnt_last(cnt_last), .irq(irq)
  );

  dma_seq u_seq (
    .clk(clk), .rst(rst), .start_go(start_go), .mode(ctrl.mode), .blen(ctrl.blen),
    .dir(ctrl.dir), .cnt_last(cnt_last), .bus_gnt(bus_gnt), .dev_ack(dev_ack),
    .busy(busy), .unit_done(unit_done), .xfer_end(xfer_end), .bus_req(bus_req),
    .dev_req(dev_req), .mem_en(mem_en), .mem_we(mem_we), .cap_dev(cap_dev),
    .cap_mem(cap_mem), .fly_wr(fly_wr), .fly_rd(fly_rd)
  );

  dma_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .word(ctrl.word), .cap_dev(cap_dev), .cap_mem(cap_mem),
    .fly_wr(fly_wr), .fly_rd(fly_rd), .dev_rdata(dev_rdata), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .dev_wdata(dev_wdata)
  );

  assign dev_port = ctrl.port;
endmodule

// File: tb/sim_dma_mover.sv
module sim_dma_mover;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        irq, bus_req, bus_gnt, mem_en, mem_we, dev_req;
  logic [15:0] mem_addr, mem_wdata, dev_wdata, dev_rdata;
  logic [15:0] mem_rdata = '0;
  logic [3:0]  dev_port;
  logic        dev_ack = 1'b0;
  logic        gnt_open = 1'b1;
  int          dev_delay = 2;
  int          cd = 0;
  int          idx = 0;
  int          rises = 0, dreq_n = 0, men_n = 0;
  logic        prev_req = 1'b0;
  logic [3:0]  port_seen = '0;
  logic [15:0] mem [256];
  logic [15:0] cap [64];
  int          checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] pat(int i);
    return 16'(((i + 1) * 4919)) ^ 16'hA55A;
  endfunction

  assign bus_gnt   = bus_req && gnt_open;
  assign dev_rdata = pat(idx);

  dma_mover u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_port(dev_port), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
  );

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en && mem_we)  mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
  end

  // peripheral model and bus monitors
  always @(negedge clk) begin
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        dev_ack = 1'b1;
        cap[idx[5:0]] = dev_wdata;
        idx = idx + 1;
      end else dev_ack = 1'b0;
    end else dev_ack = 1'b0;
    if (dev_req) begin
      cd = dev_delay;
      port_seen = dev_port;
      dreq_n = dreq_n + 1;
    end
    if (mem_en) men_n = men_n + 1;
    if (bus_req && !prev_req) rises = rises + 1;
    prev_req = bus_req;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    cfg_sel = sel;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [15:0] mk(bit dir, bit word, bit [1:0] mode, bit [3:0] blen, bit [3:0] port);
    return {2'b00, port, blen, mode, word, dir, 1'b0, 1'b1};
  endfunction

  task automatic wait_irq();
    for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
  endtask

  task automatic clear_done(string req);
    wr(2'd2, 16'h0002);
    chk({req, " irq cleared by done write"}, irq, 0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq after reset", irq, 0);
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 dev_req/mem_en after reset", {dev_req, mem_en}, 0);
    rd(2'd0, v); chk("R1 address reads 0", v, 0);
    rd(2'd1, v); chk("R1 count reads 0", v, 0);
  endtask

  task automatic t_steal_byte();
    logic [15:0] v;
    int b, r0;
    b = idx; r0 = rises; dev_delay = 2;
    wr(2'd0, 16'h0010); wr(2'd1, 16'd4);
    wr(2'd2, mk(0, 0, 2'b00, 4'd0, 4'd5));
    wait_irq();
    chk("R9 irq at end of steal transfer", irq, 1);
    chk("R4 bus requests in steal mode", rises - r0, 4);
    chk("R12 port seen at device strobe", port_seen, 5);
    for (int j = 0; j < 4; j++)
      chk("R8 byte unit stored masked", mem[8'h10 + j], {8'h00, pat(b + j) & 16'h00FF});
    rd(2'd0, v); chk("R3 byte address advanced by 1 per unit", v, 16'h0014);
    rd(2'd1, v); chk("R3 count reached zero", v, 0);
    rd(2'd2, v); chk("R9 done bit reads back", v[1], 1);
    repeat (3) @(negedge clk);
    chk("R9 irq held until acknowledged", irq, 1);
    clear_done("R9");
  endtask

  task automatic t_burst_word();
    logic [15:0] v;
    int b, r0;
    b = idx; r0 = rises; dev_delay = 4;
    wr(2'd0, 16'h0040); wr(2'd1, 16'd5);
    wr(2'd2, mk(0, 1, 2'b01, 4'd1, 4'd2));
    wait_irq();
    chk("R5 bus requests in burst mode of 2", rises - r0, 3);
    for (int j = 0; j < 5; j++)
      chk("R7 word written device to memory", mem[8'h40 + 2*j], pat(b + j));
    rd(2'd0, v); chk("R3 word address advanced by 2 per unit", v, 16'h004A);
    clear_done("R9");
  endtask

  task automatic t_fly_write();
    int b, r0, d0;
    b = idx; r0 = rises; d0 = dreq_n; dev_delay = 1;
    wr(2'd0, 16'h0080); wr(2'd1, 16'd3);
    wr(2'd2, mk(0, 1, 2'b10, 4'd7, 4'd9));
    wait_irq();
    chk("R6 fly-by releases bus per unit", rises - r0, 3);
    chk("R6 one device strobe per unit", dreq_n - d0, 3);
    for (int j = 0; j < 3; j++)
      chk("R6 fly-by data reached memory", mem[8'h80 + 2*j], pat(b + j));
    clear_done("R9");
  endtask

  task automatic t_read(bit fly, logic [15:0] a, int n);
    int b;
    b = idx; dev_delay = fly ? 1 : 3;
    wr(2'd0, a); wr(2'd1, 16'(n));
    wr(2'd2, mk(1, 1, fly ? 2'b10 : 2'b00, 4'd0, 4'd1));
    wait_irq();
    for (int j = 0; j < n; j++)
      chk(fly ? "R6 fly-by memory data to device" : "R7 memory data to device",
          cap[6'(b + j)], mem[8'(a) + 8'(2*j)]);
    clear_done("R9");
  endtask

  task automatic t_grant_and_ignore();
    logic [15:0] v;
    int d0, m0, r0;
    dev_delay = 2;
    gnt_open = 1'b0;
    wr(2'd0, 16'h00A0); wr(2'd1, 16'd3);
    d0 = dreq_n; m0 = men_n; r0 = rises;
    wr(2'd2, mk(0, 0, 2'b11, 4'd0, 4'd3));
    repeat (5) @(negedge clk);
    chk("R2 bus requested while waiting", bus_req, 1);
    chk("R2 no device or memory activity without grant", (dreq_n - d0) + (men_n - m0), 0);
    wr(2'd0, 16'h1234); wr(2'd1, 16'd9);
    rd(2'd0, v); chk("R10 address write ignored while busy", v, 16'h00A0);
    rd(2'd1, v); chk("R10 count write ignored while busy", v, 3);
    gnt_open = 1'b1;
    wait_irq();
    chk("R4 reserved mode behaves as steal", rises - r0, 3);
    rd(2'd0, v); chk("R10 transfer ran from original address", v, 16'h00A3);
    clear_done("R9");
  endtask

  task automatic t_zero();
    int r0, m0;
    r0 = rises; m0 = men_n;
    wr(2'd2, mk(0, 1, 2'b01, 4'd3, 4'd0));
    chk("R11 zero count raises irq next cycle", irq, 1);
    repeat (3) @(negedge clk);
    chk("R11 zero count uses no bus", (rises - r0) + (men_n - m0), 0);
    clear_done("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_steal_byte();
    t_burst_word();
    t_fly_write();
    t_read(0, 16'h0040, 3);
    t_read(1, 16'h0080, 2);
    t_grant_and_ignore();
    t_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule